// File: doc/BRIEF.md
# Multiple-Input Signature Register

This block compacts the response of a circuit under test into a short signature. Each clock cycle it takes one new bit for every register stage and folds the whole word into a single modular (internal-XOR) linear feedback shift register built on the feedback polynomial 1 + X + X^3. One shared register therefore serves every observed output, so there is no need for a separate compactor per output.

The register is linear, so superposition holds. The signature of several streams applied together is the XOR of the signatures each stream would give on its own from a zero seed.

A test starts by loading the seed. The block is then enabled while the circuit under test produces responses. At the end, the signature is compared against a parameterised fault-free value, and a match flag reports that comparison directly. With a 3-bit register, a faulty response collides with the good signature about one time in eight (2^-3).

Top module: `misr_compactor`

## Requirements
- R1: While `rstN` is low, the signature is held at the SEED parameter, which defaults to 3'b000.
- R2: On an enabled clock, with `signature` written as {X2,X1,X0} and `dataIn` bit i feeding stage i, the next state is X0 = X2^d0, X1 = X0^X2^d1, X2 = X1^d2.
- R3: A high `seedLoad` sets the signature to SEED on the next clock, whatever `shiftEn` and `dataIn` hold.
- R4: With `seedLoad` and `shiftEn` both low, the signature holds and `dataIn` has no effect.
- R5: `sigMatch` is high in the same cycle that the signature equals the EXPECTED parameter (default 3'b101), and low otherwise.
- R6: From seed 000, the signature of the XOR of two input streams equals the XOR of the two streams' separate signatures.
- R7: With zero input, a nonzero state returns to itself after exactly 7 enabled clocks and visits 7 distinct states. An all-zero state stays at zero.
- R8: Flipping any single input bit in one cycle of a stream changes the final signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset to the seed |
| seedLoad | input | 1 | Synchronous load of the seed; overrides enable |
| shiftEn | input | 1 | Compacts `dataIn` into the register this cycle |
| dataIn | input | WIDTH | Response word, one bit per stage |
| signature | output | WIDTH | Current register contents {X2,X1,X0} |
| sigMatch | output | 1 | High when the signature equals EXPECTED |

## Verification
The in-line assertions check three things on every clock:
- the one-step update against a shift-and-conditional-XOR formulation of the same polynomial;
- the seed load and its priority over enable;
- holding while idle, and that the control never asserts both strobes.

Properties that span a whole stream need the bench's scenarios. These are superposition of two streams, the period-7 cycle under zero input, and detection of a single flipped bit. The bench also checks the match flag against hand-computed states.

// File: rtl/misr_pkg.sv
package misr_pkg;
  typedef struct packed {
    logic loadSeed;
    logic advance;
  } misrStrobes_t;
endpackage

// File: rtl/misr_ctrl.sv
module misr_ctrl
  import misr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         seedLoad,
  input  logic         shiftEn,
  output misrStrobes_t strobes
);
  always_comb begin
    strobes.loadSeed = seedLoad;
    strobes.advance  = shiftEn & ~seedLoad;
  end

  // R3
  seed_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |-> (strobes.loadSeed && !strobes.advance));

  // R4
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!seedLoad && !shiftEn) |-> !strobes.advance && !strobes.loadSeed);

  // R2
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.loadSeed, strobes.advance}));
endmodule

// File: rtl/misr_datapath.sv
module misr_datapath
  import misr_pkg::*;
#(
  parameter int               WIDTH   = 3,
  parameter logic [WIDTH-1:0] FB_TAPS = 3'b011,
  parameter logic [WIDTH-1:0] SEED    = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  misrStrobes_t     strobes,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] state
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nextState;
  logic             feedBit;

  assign feedBit = state[TOP];

  // Stage 0 always takes the feedback; stage i takes its neighbour plus a tap.
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign nextState[i] = feedBit ^ dataIn[i];
      end else begin : g_rest
        assign nextState[i] = state[i-1] ^ (FB_TAPS[i] & feedBit) ^ dataIn[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 state <= SEED;
    else if (strobes.loadSeed) state <= SEED;
    else if (strobes.advance)  state <= nextState;
  end

  function automatic logic [WIDTH-1:0] stepRef(input logic [WIDTH-1:0] s,
                                               input logic [WIDTH-1:0] d);
    logic [WIDTH-1:0] shifted;
    shifted = {s[WIDTH-2:0], 1'b0};
    if (s[WIDTH-1]) shifted = shifted ^ (FB_TAPS | {{(WIDTH-1){1'b0}}, 1'b1});
    return shifted ^ d;
  endfunction

  // R2
  step_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> state == stepRef($past(state), $past(dataIn)));

  // R3
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSeed |=> state == SEED);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadSeed && !strobes.advance) |=> $stable(state));
endmodule

// File: rtl/misr_compactor.sv
module misr_compactor
  import misr_pkg::*;
#(
  parameter int               WIDTH    = 3,
  parameter logic [WIDTH-1:0] FB_TAPS  = 3'b011,
  parameter logic [WIDTH-1:0] SEED     = 3'b000,
  parameter logic [WIDTH-1:0] EXPECTED = 3'b101
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             seedLoad,
  input  logic             shiftEn,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] signature,
  output logic             sigMatch
);
  misrStrobes_t strobes;

  misr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .seedLoad (seedLoad),
    .shiftEn  (shiftEn),
    .strobes  (strobes)
  );

  misr_datapath #(
    .WIDTH   (WIDTH),
    .FB_TAPS (FB_TAPS),
    .SEED    (SEED)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .dataIn  (dataIn),
    .state   (signature)
  );

  assign sigMatch = (signature == EXPECTED);

  // R1
  reset_seed_chk: assert property (@(posedge clk)
    !rstN |-> signature == SEED);
endmodule

// File: tb/misr_compactor_bench.sv
`timescale 1ns/1ps
module misr_compactor_bench;
  logic       clk = 0;
  logic       rstN = 0;
  logic       seedLoad = 0;
  logic       shiftEn = 0;
  logic [2:0] dataIn = '0;
  logic [2:0] signature;
  logic       sigMatch;

  int runCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  misr_compactor u_misr_compactor (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .shiftEn(shiftEn),
    .dataIn(dataIn), .signature(signature), .sigMatch(sigMatch)
  );

  // {seedLoad, shiftEn, dataIn[2:0], expected signature[2:0]}
  localparam logic [7:0] VEC [10] = '{
    {1'b1, 1'b0, 3'b000, 3'b000},
    {1'b0, 1'b1, 3'b001, 3'b001},
    {1'b0, 1'b1, 3'b000, 3'b010},
    {1'b0, 1'b1, 3'b100, 3'b000},
    {1'b0, 1'b1, 3'b111, 3'b111},
    {1'b0, 1'b0, 3'b010, 3'b111},
    {1'b0, 1'b1, 3'b000, 3'b101},
    {1'b1, 1'b1, 3'b111, 3'b000},
    {1'b0, 1'b1, 3'b010, 3'b010},
    {1'b0, 1'b1, 3'b011, 3'b111}
  };

  localparam logic [2:0] STREAM_A [6] = '{3'b101, 3'b011, 3'b110, 3'b001, 3'b111, 3'b010};
  localparam logic [2:0] STREAM_B [6] = '{3'b010, 3'b110, 3'b001, 3'b100, 3'b011, 3'b101};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic ld, input logic en, input logic [2:0] d);
    seedLoad = ld; shiftEn = en; dataIn = d;
    @(negedge clk);
  endtask

  task automatic runStream(input logic [2:0] mask [6], input logic [2:0] other [6],
                           input logic useOther, input int flipIdx, input int flipBit,
                           output logic [2:0] sig);
    cycle(1'b1, 1'b0, 3'b000);
    for (int k = 0; k < 6; k++) begin
      logic [2:0] w;
      w = mask[k] ^ (useOther ? other[k] : 3'b000);
      if (k == flipIdx) w[flipBit] = ~w[flipBit];
      cycle(1'b0, 1'b1, w);
    end
    sig = signature;
  endtask

  initial begin
    #20000;
    failCount++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    logic [2:0] sigA, sigB, sigAB, sigF, start;
    logic [7:0] seen;
    @(negedge clk);
    // R1 reset state
    check("R1 reset signature", signature, 3'b000);
    check("R5 match low at reset", sigMatch, 1'b0);
    @(negedge clk);
    rstN = 1;

    // R2 R3 R4 R5 vector table
    foreach (VEC[i]) begin
      cycle(VEC[i][7], VEC[i][6], VEC[i][5:3]);
      check("R2/R3/R4 table signature", signature, VEC[i][2:0]);
      check("R5 table match", sigMatch, VEC[i][2:0] == 3'b101);
    end

    // R4: idle with busy data leaves the state
    cycle(1'b0, 1'b0, 3'b101);
    cycle(1'b0, 1'b0, 3'b110);
    check("R4 idle hold", signature, 3'b111);

    // R3: load overrides enable
    cycle(1'b1, 1'b1, 3'b101);
    check("R3 load over enable", signature, 3'b000);

    // R7: zero stays zero
    for (int k = 0; k < 5; k++) cycle(1'b0, 1'b1, 3'b000);
    check("R7 zero lock", signature, 3'b000);

    // R7: period 7
    cycle(1'b0, 1'b1, 3'b001);
    start = signature;
    seen = '0;
    seen[start] = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      cycle(1'b0, 1'b1, 3'b000);
      if (k < 7) begin
        check("R7 no early return", signature == start, 1'b0);
        seen[signature] = 1'b1;
      end
    end
    check("R7 period seven", signature, start);
    check("R7 seven distinct states", $countones(seen), 7);

    // R6 superposition
    runStream(STREAM_A, STREAM_B, 1'b0, -1, 0, sigA);
    runStream(STREAM_B, STREAM_A, 1'b0, -1, 0, sigB);
    runStream(STREAM_A, STREAM_B, 1'b1, -1, 0, sigAB);
    check("R6 superposition", sigAB, sigA ^ sigB);

    // R8 single-bit error detection
    for (int k = 0; k < 6; k++) begin
      for (int b = 0; b < 3; b++) begin
        runStream(STREAM_A, STREAM_B, 1'b0, k, b, sigF);
        check("R8 single flip detected", sigF != sigA, 1'b1);
      end
    end

    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule